// File: doc/BRIEF.md
# Two-Bit Zero-Operand Bit-Serial Processor Core

This core runs a program whose instructions are two bits wide and carry no operand field. Its only data storage is an internal memory of one-bit words. The lowest data bits serve as memory-mapped literal registers. One literal gives the next data address, and the other gives the branch target. The core holds a data address register `w` and a program counter `pc`. Each clock cycle it fetches one opcode from an external program memory, at the address it drives out, and completes that instruction.

Four operations exist:
- set the addressed bit;
- clear the addressed bit;
- arm, which moves the address literal into `w` and wipes that literal in the same step;
- conditional branch, which either falls through or jumps to the target literal, depending on the addressed bit.

An optional extension gives indirect addressing and computed jumps. Setting one of two trigger bits first refreshes the matching literal from a separate copy field. A debug port reads any data bit, and a second output shows `w`, so results can be observed from outside.

Top module: `zop_core`

## Requirements
- R1: The opcode on `pm_op` is fetched from address `pm_addr` (equal to `pc`), and one instruction completes per clock cycle. The encoding is set=00, clear=01, arm=10, branch=11.
- R2: While `rst_n` is low, `pc` and `w` are zero and every data bit is 0.
- R3: Set writes 1 to data bit `w`, and clear writes 0 to data bit `w`.
- R4: Set and clear add one to `w`, wrapping from 1023 to 0. Arm and branch do not change `w` except as R6 states.
- R5: Set, clear and arm add one to `pc`, wrapping from 4095 to 0.
- R6: Arm loads `w` with the old address literal and clears all of its bits to 0. The address literal is data bits 0 to 9, with bit 0 as its LSB.
- R7: When data bit `w` is 1, branch adds one to `pc`. When it is 0, branch loads `pc` from the target literal, which is data bits 10 to 21 with bit 10 as its LSB.
- R8: With the extension, a set at address 22 first copies data bits 24 to 33 into the address literal (bit 24 goes to bit 0), and then sets bit 22.
- R9: With the extension, a set at address 23 first copies data bits 34 to 45 into the target literal (bit 34 goes to bit 10), and then sets bit 23.
- R10: A clear at address 22 or 23 copies nothing, and both literals keep their values.
- R11: `dbg_bit` shows data bit `dbg_addr` combinationally, and `dbg_w` shows `w`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_addr | output | 12 | Program memory address (the program counter) |
| pm_op | input | 2 | Opcode read from program memory |
| dbg_addr | input | 10 | Debug read address into data memory |
| dbg_bit | output | 1 | Data bit at `dbg_addr` |
| dbg_w | output | 10 | Current data address register |

## Verification
The bench builds the core with its default widths (10-bit data address, 12-bit program counter) and with the extension enabled. At these widths the latch addresses 22 and 23 and the copy fields sit where a short directed program can reach them. Long runs of set or clear opcodes make both `w` and `pc` wrap within a few thousand cycles. A random program then mixes arms, taken and untaken branches and latch-triggered copies at addresses chosen by the data itself.

// File: rtl/zop_pkg.sv
package zop_pkg;
   typedef enum logic [1:0] {
      OP_SET = 2'b00,
      OP_CLR = 2'b01,
      OP_ARM = 2'b10,
      OP_BRA = 2'b11
   } op_e;
endpackage

// File: rtl/zop_bitmem.sv
module zop_bitmem
   import zop_pkg::*;
#(
   parameter int AW  = 10,
   parameter int PW  = 12,
   parameter bit EXT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  op_e           op,
   input  logic [AW-1:0] w,
   output logic          rd_bit,
   output logic [AW-1:0] wl,
   output logic [PW-1:0] pcl,
   input  logic [AW-1:0] dbg_addr,
   output logic          dbg_bit
);
   localparam int DEPTH  = 1 << AW;
   localparam int WLAT   = AW + PW;
   localparam int PLAT   = WLAT + 1;
   localparam int WC_LO  = WLAT + 2;
   localparam int PCC_LO = WC_LO + AW;
   localparam int USED   = EXT ? (PCC_LO + PW) : WLAT;

   if (USED > DEPTH) begin : g_size_bad
      $fatal(1, "zop_bitmem: literal fields do not fit in data memory");
   end

   logic [DEPTH-1:0] mem_q, mem_d;
   logic [AW-1:0]    wc_v;
   logic [PW-1:0]    pcc_v;
   logic             cp_wl, cp_pcl;

   generate
      if (EXT) begin : g_ind
         assign wc_v   = mem_q[WC_LO +: AW];
         assign pcc_v  = mem_q[PCC_LO +: PW];
         assign cp_wl  = (op == OP_SET) && (w == AW'(WLAT));
         assign cp_pcl = (op == OP_SET) && (w == AW'(PLAT));
      end else begin : g_plain
         assign wc_v   = '0;
         assign pcc_v  = '0;
         assign cp_wl  = 1'b0;
         assign cp_pcl = 1'b0;
      end
   endgenerate

   always_comb begin
      mem_d = mem_q;
      unique case (op)
         OP_SET: begin
            if (cp_wl)  mem_d[0 +: AW]  = wc_v;
            if (cp_pcl) mem_d[AW +: PW] = pcc_v;
            mem_d[w] = 1'b1;
         end
         OP_CLR: mem_d[w] = 1'b0;
         OP_ARM: mem_d[0 +: AW] = '0;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mem_q <= '0;
      else        mem_q <= mem_d;
   end

   assign rd_bit  = mem_q[w];
   assign wl      = mem_q[0 +: AW];
   assign pcl     = mem_q[AW +: PW];
   assign dbg_bit = mem_q[dbg_addr];
endmodule

// File: rtl/zop_seq.sv
module zop_seq
   import zop_pkg::*;
#(
   parameter int AW = 10,
   parameter int PW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  op_e           op,
   input  logic          rd_bit,
   input  logic [AW-1:0] wl,
   input  logic [PW-1:0] pcl,
   output logic [PW-1:0] pc_q,
   output logic [AW-1:0] w_q
);
   logic [PW-1:0] pc_d;
   logic [AW-1:0] w_d;

   always_comb begin
      pc_d = pc_q + 1'b1;
      w_d  = w_q;
      unique case (op)
         OP_SET, OP_CLR: w_d = w_q + 1'b1;
         OP_ARM:         w_d = wl;
         OP_BRA:         if (!rd_bit) pc_d = pcl;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= '0;
         w_q  <= '0;
      end else begin
         pc_q <= pc_d;
         w_q  <= w_d;
      end
   end
endmodule

// File: rtl/zop_core.sv
module zop_core
   import zop_pkg::*;
#(
   parameter int AW  = 10,
   parameter int PW  = 12,
   parameter bit EXT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] pm_addr,
   input  logic [1:0]    pm_op,
   input  logic [AW-1:0] dbg_addr,
   output logic          dbg_bit,
   output logic [AW-1:0] dbg_w
);
   if (AW < 2 || PW < 2) begin : g_width_bad
      $fatal(1, "zop_core: address widths too small");
   end

   op_e           op;
   logic [AW-1:0] w_q;
   logic [AW-1:0] wl_v;
   logic [PW-1:0] pcl_v;
   logic          rd_bit;

   assign op = op_e'(pm_op);

   zop_bitmem #(.AW(AW), .PW(PW), .EXT(EXT)) u_mem (
      .clk(clk), .rst_n(rst_n), .op(op), .w(w_q), .rd_bit(rd_bit),
      .wl(wl_v), .pcl(pcl_v), .dbg_addr(dbg_addr), .dbg_bit(dbg_bit)
   );

   zop_seq #(.AW(AW), .PW(PW)) u_seq (
      .clk(clk), .rst_n(rst_n), .op(op), .rd_bit(rd_bit),
      .wl(wl_v), .pcl(pcl_v), .pc_q(pm_addr), .w_q(w_q)
   );

   assign dbg_w = w_q;
endmodule

// File: rtl/zop_chk.sv
module zop_chk #(
   parameter int AW = 10,
   parameter int PW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    op,
   input logic [PW-1:0] pc,
   input logic [AW-1:0] w,
   input logic [AW-1:0] wl,
   input logic [PW-1:0] pcl,
   input logic          rd_bit
);
   a_r2_reset_pc: assert property (@(posedge clk) !rst_n |=> pc == '0);

   a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      op != 2'b11 |=> pc == PW'($past(pc) + 1'b1));

   a_r4_w_step: assert property (@(posedge clk) disable iff (!rst_n)
      op[1] == 1'b0 |=> w == AW'($past(w) + 1'b1));

   a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
      op == 2'b10 |=> (w == $past(wl)) && (wl == '0));

   a_r7_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b11 && !rd_bit) |=> pc == $past(pcl));

   a_r7_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b11 && rd_bit) |=> (pc == PW'($past(pc) + 1'b1)) && $stable(w));
endmodule

bind zop_core zop_chk #(.AW(AW), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .op(pm_op), .pc(pm_addr), .w(w_q),
   .wl(wl_v), .pcl(pcl_v), .rd_bit(rd_bit)
);

// File: tb/sim_zop_core.sv
`timescale 1ns/1ps
module sim_zop_core;
   localparam int AW = 10;
   localparam int PW = 12;
   localparam int DM = 1 << AW;
   localparam int PM = 1 << PW;
   localparam int WLAT = AW + PW;
   localparam int PLAT = WLAT + 1;
   localparam int WC0  = WLAT + 2;
   localparam int PCC0 = WC0 + AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PW-1:0] pm_addr;
   logic [1:0]    pm_op;
   logic [AW-1:0] dbg_addr = '0;
   logic          dbg_bit;
   logic [AW-1:0] dbg_w;

   logic [1:0] prog [PM];
   int total = 0, bad = 0, ptr = 0, base = 0;
   int ref_pc, ref_w, prev_op;
   bit ref_dm [DM];
   bit done = 0;

   always #5 clk = ~clk;

   // R1: opcode fetched from the address the core drives
   assign pm_op = prog[pm_addr];

   zop_core #(.AW(AW), .PW(PW), .EXT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_op(pm_op),
      .dbg_addr(dbg_addr), .dbg_bit(dbg_bit), .dbg_w(dbg_w)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic read_field(input int lo, input int n, output int v);
      v = 0;
      for (int i = 0; i < n; i++) begin
         dbg_addr = AW'(lo + i);
         #0.02;
         if (dbg_bit) v += (1 << i);
      end
   endtask

   task automatic ref_step();
      int op, v;
      op = prog[ref_pc];
      case (op)
         0, 1: begin
            if (op == 0 && ref_w == WLAT)
               for (int i = 0; i < AW; i++) ref_dm[i] = ref_dm[WC0 + i];
            if (op == 0 && ref_w == PLAT)
               for (int i = 0; i < PW; i++) ref_dm[AW + i] = ref_dm[PCC0 + i];
            ref_dm[ref_w] = (op == 0);
            ref_w  = (ref_w + 1) % DM;
            ref_pc = (ref_pc + 1) % PM;
         end
         2: begin
            v = 0;
            for (int i = 0; i < AW; i++) begin
               if (ref_dm[i]) v += (1 << i);
               ref_dm[i] = 0;
            end
            ref_w  = v;
            ref_pc = (ref_pc + 1) % PM;
         end
         default: begin
            if (ref_dm[ref_w]) ref_pc = (ref_pc + 1) % PM;
            else begin
               v = 0;
               for (int i = 0; i < PW; i++) if (ref_dm[AW + i]) v += (1 << i);
               ref_pc = v;
            end
         end
      endcase
      prev_op = op;
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
         ref_step();
         chk(prev_op == 3 ? "R1 R7 pc" : "R1 R5 pc", int'(pm_addr), ref_pc);
         chk(prev_op == 2 ? "R6 w" : "R4 w", int'(dbg_w), ref_w);
         for (int i = 0; i < 64; i++) begin
            dbg_addr = AW'(base + i);
            #0.02;
            chk("R3 R11 dbg_bit", int'(dbg_bit), int'(ref_dm[base + i]));
         end
         base = (base + 64) % DM;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk("R2 pc", int'(pm_addr), 0);
      chk("R2 w", int'(dbg_w), 0);
      for (int i = 0; i < 64; i++) begin
         dbg_addr = AW'(i);
         #0.02;
         chk("R2 dm", int'(dbg_bit), 0);
      end
      for (int i = 0; i < DM; i++) ref_dm[i] = 0;
      ref_pc = 0;
      ref_w = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic fill(input logic [1:0] o);
      for (int i = 0; i < PM; i++) prog[i] = o;
      ptr = 0;
   endtask

   task automatic put(input logic [1:0] o);
      prog[ptr] = o;
      ptr++;
   endtask

   task automatic put_val(input int val, input int n);
      for (int i = 0; i < n; i++) put(((val >> i) & 1) != 0 ? 2'b00 : 2'b01);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v;

      // Directed: literals, latch copies, arm, both branch outcomes
      fill(2'b01);
      put_val(22, AW);      // address literal = 22
      put_val(5, PW);       // target literal = 5
      put(2'b01);           // clear at 22: no copy (R10)
      put(2'b01);           // clear at 23: no copy (R10)
      put_val(23, AW);      // copy field for address literal
      put_val(2000, PW);    // copy field for target literal
      put(2'b10);           // arm -> w = 22
      put(2'b00);           // set at 22 -> copy (R8)
      put(2'b00);           // set at 23 -> copy (R9)
      put(2'b10);           // arm -> w = 23
      put(2'b11);           // bit 23 is 1 -> fall through
      put(2'b11);           // fall through again
      put(2'b01);           // clear bit 23, w = 24
      put(2'b10);           // arm -> w = 0
      put(2'b11);           // bit 0 is 0 -> jump to 2000
      do_reset();
      run(46);
      read_field(0, AW, v);  chk("R10 wl kept", v, 22);
      read_field(AW, PW, v); chk("R10 pcl kept", v, 5);
      run(1);
      chk("R6 w from wl", int'(dbg_w), 22);
      read_field(0, AW, v);  chk("R6 wl cleared", v, 0);
      run(1);
      read_field(0, AW, v);  chk("R8 wl copied", v, 23);
      read_field(WLAT, 1, v); chk("R8 latch set", v, 1);
      run(1);
      read_field(AW, PW, v); chk("R9 pcl copied", v, 2000);
      read_field(PLAT, 1, v); chk("R9 latch set", v, 1);
      run(1);
      chk("R6 w arm", int'(dbg_w), 23);
      run(2);
      chk("R7 fall through", int'(pm_addr), 52);
      chk("R7 w kept", int'(dbg_w), 23);
      run(3);
      chk("R7 jump taken", int'(pm_addr), 2000);
      run(20);

      // w wraps under a long run of clears
      fill(2'b01);
      do_reset();
      run(1024);
      chk("R4 w wrap", int'(dbg_w), 0);
      run(1);
      chk("R4 w after wrap", int'(dbg_w), 1);

      // pc wraps under a long run of sets
      fill(2'b00);
      do_reset();
      run(PM);
      chk("R5 pc wrap", int'(pm_addr), 0);
      run(4);

      // Random program
      for (int i = 0; i < PM; i++) prog[i] = 2'($urandom_range(0, 3));
      do_reset();
      run(6000);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule